// File: doc/BRIEF.md
# I2C Register Slave with Auto-Incrementing Index

This block lets an I2C master read and write a bank of byte-wide control registers. The registers sit outside the block; it only holds the register index. The block drives a plain register-file port: `rf_addr` always shows the current index, `rf_we` pulses for one clock with the byte to store, and `rf_rdata` is looked up combinationally at `rf_addr`. Its 7-bit bus address is a fixed five-bit prefix followed by two strap pins, so four copies can share one bus.

The first byte of a write transfer after the address byte loads the index. Any further bytes are stored at the index, which steps by one after each accepted byte and wraps from 0x7F to 0x00. A byte aimed at an index outside the writable window is refused. To read, the master loads the index with a short write, issues a repeated START, and reads a burst. The master's ACK after each byte asks for the next byte, and a NACK ends the burst. Both bus lines are re-timed to the system clock and pass through a majority vote, so one-clock spikes are ignored.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The block acknowledges (pulls SDA low in the ninth clock) only the address byte whose upper seven bits equal {10011, addr_sel}. Any other address gets no acknowledge, and the block ignores the bus until the next START.
- R2: In a write transfer, the byte after the address byte loads the index. Each following byte that is accepted is acknowledged and produces exactly one single-clock `rf_we` pulse, with `rf_addr` equal to the index and `rf_wdata` equal to the byte.
- R3: After each accepted write byte, the index (seen on `rf_addr`) steps up by exactly one.
- R4: The index that follows 0x7F is 0x00.
- R5: A write byte aimed at an index outside WR_LO..WR_HI (default 0x10..0x17) is not acknowledged, gives no `rf_we`, and leaves the index unchanged. The rest of that transfer is ignored.
- R6: Read data is sent MSB first. The first byte read after the index byte is loaded comes from that index with no increment. Each byte requested by a master ACK comes from the next index.
- R7: Reads from any index in RD_LO..RD_HI (default 0x10..0x1F) return `rf_rdata`, including the part that cannot be written. Reads from other indices return 0x00.
- R8: After the master NACKs a read byte, the block releases SDA and does not drive it again before the next START.
- R9: A pulse lasting one system clock on SCL or SDA has no effect on the transfer.
- R10: A STOP at any point ends the transfer, leaves SDA released, and writes nothing for a partly received byte.
- R11: After reset: SDA released, `rf_we` low, index 0x00.
- R12: A read transfer that is not directly preceded by an index load steps the index by one before its first byte.
- R13: The block changes its SDA drive only while the filtered SCL is low, or in answer to a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample and filter the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 2 | Strap pins giving the low two address bits |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | High to pull SDA low (open drain) |
| rf_addr | output | 7 | Current register index |
| rf_we | output | 1 | One-clock write strobe |
| rf_wdata | output | 8 | Byte to store at rf_addr |
| rf_rdata | input | 8 | Register content at rf_addr |

## Verification
The assertions assume the SCL and SDA inputs are synchronous to nothing. They also assume every bus level is held for several system clocks, so that after filtering a rise and a fall of SCL never fall in the same cycle. The stimulus master changes SDA only a quarter bit after SCL falls, except for deliberate START and STOP conditions. Its only glitches last exactly one system clock, so the filter must reject them. A register-file model in the bench answers `rf_rdata` combinationally, as the block expects.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  localparam int RS_IDX_W  = 7;
  localparam int RS_BYTE_W = 8;
  localparam int RS_PFX_W  = 5;
  localparam int RS_SEL_W  = 2;
  localparam int RS_CNT_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_IDX, ST_IDX_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RDAT_ACK
  } rs_state_t;

  // two-of-three vote
  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  function automatic logic dev_match(input logic [RS_BYTE_W-1:0] b,
                                     input logic [RS_PFX_W-1:0] pfx,
                                     input logic [RS_SEL_W-1:0] sel);
    return b[RS_BYTE_W-1:1] == {pfx, sel};
  endfunction

  function automatic logic idx_in(input logic [RS_IDX_W-1:0] i,
                                  input logic [RS_IDX_W-1:0] lo,
                                  input logic [RS_IDX_W-1:0] hi);
    return (i >= lo) && (i <= hi);
  endfunction

  // wraps naturally at the index width
  function automatic logic [RS_IDX_W-1:0] idx_next(input logic [RS_IDX_W-1:0] i);
    return i + 1'b1;
  endfunction
endpackage

// File: rtl/i2c_rs_filter.sv
module i2c_rs_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  import i2c_rs_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   tap_q;
  logic                   vote;

  generate
    if (VOTE_TAPS == 3) begin : g_maj3
      assign vote = maj3(tap_q);
    end else begin : g_majn
      assign vote = ($countones(tap_q) > (VOTE_TAPS / 2));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      tap_q  <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      tap_q  <= {tap_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      dout   <= vote;
    end
  end
endmodule

// File: rtl/i2c_rs_events.sv
module i2c_rs_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic evt_rise,
  output logic evt_fall,
  output logic evt_start,
  output logic evt_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign evt_rise  = scl_f & ~scl_q;
  assign evt_fall  = ~scl_f & scl_q;
  assign evt_start = scl_f & scl_q & sda_q & ~sda_f;
  assign evt_stop  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_rs_engine.sv
module i2c_rs_engine
  import i2c_rs_pkg::*;
#(
  parameter logic [RS_PFX_W-1:0] DEV_PFX = 5'b10011,
  parameter logic [RS_IDX_W-1:0] WR_LO   = 7'h10,
  parameter logic [RS_IDX_W-1:0] WR_HI   = 7'h17,
  parameter logic [RS_IDX_W-1:0] RD_LO   = 7'h10,
  parameter logic [RS_IDX_W-1:0] RD_HI   = 7'h1F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RS_SEL_W-1:0]  addr_sel,
  input  logic                 sda_f,
  input  logic                 evt_rise,
  input  logic                 evt_fall,
  input  logic                 evt_start,
  input  logic                 evt_stop,
  input  logic [RS_BYTE_W-1:0] rf_rdata,
  output logic                 sda_oe,
  output logic [RS_IDX_W-1:0]  rf_addr,
  output logic                 rf_we,
  output logic [RS_BYTE_W-1:0] rf_wdata
);
  localparam logic [RS_CNT_W-1:0] BITS = RS_CNT_W'(RS_BYTE_W);

  rs_state_t            st;
  logic [RS_BYTE_W-1:0] shreg;
  logic [RS_CNT_W-1:0]  cnt;
  logic [RS_IDX_W-1:0]  idx;
  logic                 rnw, first_rd, mack, ld;
  logic [RS_BYTE_W-1:0] rd_byte;

  assign rf_addr = idx;
  assign rd_byte = idx_in(idx, RD_LO, RD_HI) ? rf_rdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      shreg    <= '0;
      cnt      <= '0;
      idx      <= '0;
      rnw      <= 1'b0;
      first_rd <= 1'b0;
      mack     <= 1'b1;
      ld       <= 1'b0;
      sda_oe   <= 1'b0;
      rf_we    <= 1'b0;
      rf_wdata <= '0;
    end else begin
      rf_we <= 1'b0;
      ld    <= 1'b0;
      if (ld) begin
        shreg  <= rd_byte;
        sda_oe <= ~rd_byte[RS_BYTE_W-1];
        cnt    <= '0;
      end
      if (evt_stop) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (evt_start) begin
        st     <= ST_ADDR;
        sda_oe <= 1'b0;
        cnt    <= '0;
      end else begin
        case (st)
          ST_ADDR, ST_IDX, ST_WDAT: begin
            if (evt_rise && cnt < BITS) begin
              shreg <= {shreg[RS_BYTE_W-2:0], sda_f};
              cnt   <= cnt + 1'b1;
            end else if (evt_fall && cnt == BITS) begin
              case (st)
                ST_ADDR: begin
                  if (dev_match(shreg, DEV_PFX, addr_sel)) begin
                    sda_oe <= 1'b1;
                    rnw    <= shreg[0];
                    st     <= ST_ADDR_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                ST_IDX: begin
                  idx      <= shreg[RS_IDX_W-1:0];
                  first_rd <= 1'b1;
                  sda_oe   <= 1'b1;
                  st       <= ST_IDX_ACK;
                end
                default: begin
                  if (idx_in(idx, WR_LO, WR_HI)) begin
                    sda_oe   <= 1'b1;
                    rf_we    <= 1'b1;
                    rf_wdata <= shreg;
                    st       <= ST_WDAT_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
              endcase
            end
          end
          ST_ADDR_ACK: begin
            if (evt_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              if (rnw) begin
                if (!first_rd) idx <= idx_next(idx);
                first_rd <= 1'b0;
                ld       <= 1'b1;
                st       <= ST_RDAT;
              end else begin
                st <= ST_IDX;
              end
            end
          end
          ST_IDX_ACK: begin
            if (evt_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_WDAT;
            end
          end
          ST_WDAT_ACK: begin
            if (evt_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              idx    <= idx_next(idx);
              st     <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (evt_rise) begin
              cnt <= cnt + 1'b1;
            end else if (evt_fall) begin
              if (cnt == BITS) begin
                sda_oe <= 1'b0;
                st     <= ST_RDAT_ACK;
              end else begin
                shreg  <= {shreg[RS_BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[RS_BYTE_W-2];
              end
            end
          end
          ST_RDAT_ACK: begin
            if (evt_rise) begin
              mack <= sda_f;
            end else if (evt_fall) begin
              if (!mack) begin
                idx <= idx_next(idx);
                ld  <= 1'b1;
                st  <= ST_RDAT;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [4:0] DEV_PFX     = 5'b10011,
  parameter logic [6:0] WR_LO       = 7'h10,
  parameter logic [6:0] WR_HI       = 7'h17,
  parameter logic [6:0] RD_LO       = 7'h10,
  parameter logic [6:0] RD_HI       = 7'h1F,
  parameter int         SYNC_STAGES = 2,
  parameter int         VOTE_TAPS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr_sel,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [6:0] rf_addr,
  output logic       rf_we,
  output logic [7:0] rf_wdata,
  input  logic [7:0] rf_rdata
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines, flt_lines;
  logic scl_f, sda_f;
  logic evt_rise, evt_fall, evt_start, evt_stop;

  assign raw_lines = {sda_i, scl_i};
  assign scl_f     = flt_lines[0];
  assign sda_f     = flt_lines[1];

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_flt
      i2c_rs_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_flt (
        .clk(clk), .rst_n(rst_n), .din(raw_lines[g]), .dout(flt_lines[g])
      );
    end
  endgenerate

  i2c_rs_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .evt_rise(evt_rise), .evt_fall(evt_fall),
    .evt_start(evt_start), .evt_stop(evt_stop)
  );

  i2c_rs_engine #(
    .DEV_PFX(DEV_PFX), .WR_LO(WR_LO), .WR_HI(WR_HI), .RD_LO(RD_LO), .RD_HI(RD_HI)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .sda_f(sda_f),
    .evt_rise(evt_rise), .evt_fall(evt_fall),
    .evt_start(evt_start), .evt_stop(evt_stop),
    .rf_rdata(rf_rdata), .sda_oe(sda_oe), .rf_addr(rf_addr),
    .rf_we(rf_we), .rf_wdata(rf_wdata)
  );
endmodule

// File: rtl/i2c_rs_checker.sv
module i2c_rs_checker #(
  parameter logic [6:0] WR_LO = 7'h10,
  parameter logic [6:0] WR_HI = 7'h17
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       evt_start,
  input logic       evt_stop,
  input logic       sda_oe,
  input logic       rf_we,
  input logic [6:0] rf_addr
);
  assert_we_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  assert_we_holds_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> $stable(rf_addr));

  assert_we_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_addr >= WR_LO && rf_addr <= WR_HI));

  assert_stop_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |=> !sda_oe);

  assert_drive_on_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_f) || $past(evt_start) || $past(evt_stop)));
endmodule

bind i2c_regbank_slave i2c_rs_checker #(.WR_LO(WR_LO), .WR_HI(WR_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .evt_start(evt_start),
  .evt_stop(evt_stop), .sda_oe(sda_oe), .rf_we(rf_we), .rf_addr(rf_addr)
);

// File: tb/sim_i2c_regbank_slave.sv
module sim_i2c_regbank_slave;
  localparam int Q = 10;
  localparam logic [1:0] SEL = 2'b10;
  localparam logic [7:0] WADDR = {5'b10011, SEL, 1'b0};
  localparam logic [7:0] RADDR = {5'b10011, SEL, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, rf_we;
  logic [6:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  logic [6:0] m_idx = '0;
  logic [7:0] regs [128];
  logic [7:0] exp_regs [128];
  logic [14:0] wq [$];
  logic [14:0] got;

  always #10 clk = ~clk;

  i2c_regbank_slave u0 (
    .clk(clk), .rst_n(rst_n), .addr_sel(SEL), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata)
  );

  function automatic logic [7:0] rom(input logic [6:0] a);
    return {a[3:0], ~a[3:0]};
  endfunction

  // register-file model: upper half of the read window is fixed content
  assign rf_rdata = (rf_addr >= 7'h18 && rf_addr <= 7'h1F) ? rom(rf_addr) : regs[rf_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) regs[i] <= '0;
    end else if (rf_we) begin
      regs[rf_addr] <= rf_wdata;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [6:0] a);
    if (a >= 7'h18 && a <= 7'h1F) return rom(a);
    if (a >= 7'h10 && a <= 7'h17) return exp_regs[a];
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected write for every strobe seen
  always @(negedge clk) begin
    if (rst_n && rf_we) begin
      if (wq.size() == 0) chk(1'b0, "R2 unexpected write", {rf_addr, rf_wdata}, 0);
      else begin
        got = wq.pop_front();
        chk({rf_addr, rf_wdata} == got, "R2 write strobe", {rf_addr, rf_wdata}, got);
      end
    end
  end

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic put_byte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (glitch && i == 4) begin
        repeat (3) @(negedge clk); scl_m = 1'b1; @(negedge clk); scl_m = 1'b0;
        repeat (Q - 4) @(negedge clk);
      end else hq();
      scl_m = 1'b1; hq();
      if (glitch && i == 2) begin
        sda_m = ~sda_m; @(negedge clk); sda_m = ~sda_m; repeat (Q - 1) @(negedge clk);
      end else hq();
      scl_m = 1'b0; hq();
    end
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); acked = !sda_line; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic get_byte(input bit ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hq(); scl_m = 1'b1; hq(); b[i] = sda_line; hq(); scl_m = 1'b0; hq();
    end
    sda_m = ack ? 1'b0 : 1'b1; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
    sda_m = 1'b1;
  endtask

  // driver: write transfer, expected strobes pushed to the scoreboard
  task automatic reg_write(input logic [6:0] idx, input logic [7:0] d [4], input int n);
    bit ak, dead;
    logic [6:0] cur;
    dead = 1'b0;
    bus_start();
    put_byte(WADDR, 1'b0, ak); chk(ak, "R1 address ack", ak, 1);
    put_byte({1'b0, idx}, 1'b0, ak); chk(ak, "R2 index ack", ak, 1);
    cur = idx;
    for (int k = 0; k < n; k++) begin
      bit ok;
      ok = !dead && cur >= 7'h10 && cur <= 7'h17;
      if (ok) begin wq.push_back({cur, d[k]}); exp_regs[cur] = d[k]; end
      put_byte(d[k], 1'b0, ak);
      chk(ak == ok, ok ? "R2 data ack" : "R5 refused byte", ak, ok);
      if (ok) cur = cur + 1'b1; else dead = 1'b1;
    end
    bus_stop();
    m_idx = cur;
    chk(rf_addr == cur, "R3 index after write", rf_addr, cur);
  endtask

  task automatic reg_read(input bit set_idx, input logic [6:0] idx, input int n,
                          input bit extra, input string tag);
    bit ak;
    logic [6:0] cur;
    logic [7:0] b;
    if (set_idx) begin
      bus_start();
      put_byte(WADDR, 1'b0, ak); chk(ak, "R1 address ack", ak, 1);
      put_byte({1'b0, idx}, 1'b0, ak); chk(ak, "R2 index ack", ak, 1);
      cur = idx;
    end else cur = m_idx + 1'b1;
    bus_start();
    put_byte(RADDR, 1'b0, ak); chk(ak, "R1 read address ack", ak, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(k < n - 1, b);
      chk(b == exp_rd(cur), tag, b, exp_rd(cur));
      if (k < n - 1) cur = cur + 1'b1;
    end
    if (extra) begin
      get_byte(1'b0, b);
      chk(b == 8'hFF, "R8 released after NACK", b, 8'hFF);
    end
    bus_stop();
    m_idx = cur;
    chk(rf_addr == cur, tag, rf_addr, cur);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit ak;
    for (int i = 0; i < 128; i++) exp_regs[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
    chk(rf_we == 1'b0, "R11 no strobe", rf_we, 0);
    chk(rf_addr == 7'h00, "R11 index zero", rf_addr, 0);

    // R1: other strap value is not answered
    bus_start();
    put_byte({5'b10011, 2'b00, 1'b0}, 1'b0, ak);
    chk(!ak, "R1 foreign address", ak, 0);
    bus_stop();

    // R2/R3: burst write 0x10..0x13
    reg_write(7'h10, '{8'hA5, 8'h3C, 8'h96, 8'h0F}, 4);
    // R5: window edge, refused byte and the one after it
    reg_write(7'h17, '{8'h11, 8'h22, 8'h33, 8'h00}, 3);
    chk(rf_addr == 7'h18, "R5 index unchanged", rf_addr, 7'h18);

    // R6 and R8: read 0x10..0x12 then clock an extra byte after NACK
    reg_read(1'b1, 7'h10, 3, 1'b1, "R6 burst read");
    // R12: new read continues from next index
    reg_read(1'b0, 7'h00, 1, 1'b0, "R12 read without index load");
    // R7: unwritable part of the window, then outside it
    reg_read(1'b1, 7'h1E, 3, 1'b0, "R7 read window");
    // R4: wrap from 0x7F
    reg_read(1'b1, 7'h7F, 2, 1'b0, "R4 index wrap");
    chk(rf_addr == 7'h00, "R4 index is zero", rf_addr, 0);

    // R9: glitched byte to 0x14
    bus_start();
    put_byte(WADDR, 1'b0, ak); chk(ak, "R9 address ack", ak, 1);
    put_byte(8'h14, 1'b0, ak); chk(ak, "R9 index ack", ak, 1);
    wq.push_back({7'h14, 8'h5A}); exp_regs[7'h14] = 8'h5A;
    put_byte(8'h5A, 1'b1, ak); chk(ak, "R9 glitched byte ack", ak, 1);
    bus_stop();
    chk(rf_addr == 7'h15, "R9 index after glitch", rf_addr, 7'h15);

    // R10: STOP in the middle of a data byte
    bus_start();
    put_byte(WADDR, 1'b0, ak);
    put_byte(8'h15, 1'b0, ak);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
    end
    bus_stop();
    repeat (10) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
    chk(rf_addr == 7'h15, "R10 no partial write", rf_addr, 7'h15);
    reg_write(7'h15, '{8'hC3, 8'h00, 8'h00, 8'h00}, 1);
    reg_read(1'b1, 7'h14, 2, 1'b0, "R10 data after abort");

    repeat (20) @(negedge clk);
    chk(wq.size() == 0, "R2 pending writes", wq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule